// File: doc/BRIEF.md
# I2C Single-Byte Register-Access Master

This block is a bus master for a two-wire serial bus. It performs one complete register access against an EEPROM-style slave that takes an 8-bit byte address. The host presents a request: a 7-bit slave address with the read/write selector in bit 0, a byte address and a write byte. It then pulses a start strobe. The block generates the clock line and controls the data line only through an output enable, where 1 pulls the line low and 0 releases it. It reads the line back through a sampled input.

The access always follows the combined format. The slave address first goes out with the direction bit forced to write, followed by the byte address. A write then sends the data byte and a STOP. A read issues a repeated START, sends the slave address with the read bit, takes in one byte, answers it with a NACK and ends with a STOP.

Completion is reported in a 16-bit state word and by a one-cycle interrupt pulse. The status byte sits in the upper half and the current phase code in the lower half. A missing acknowledge ends the access at once, with no STOP. Bus timing comes from a programmable count of timebase ticks. A separate init strobe releases both lines and abandons any access in progress.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, scl_o is 1, sda_oe_o is 0, state_o is 0x0000 and irq_o is 0.
- R2: A start strobe accepted while idle latches the request. In the next cycle it shows sda_oe_o=1 with scl_o=1, which is a START. state_o reads 0x0003: status byte 0x00 and phase code 0x03. The first address byte always carries 0 in bit 0, even when a read is requested.
- R3: With bit 0 of slave_addr_i at 0 (write), the bus carries exactly one START, then {addr,0}, ACK, byte address, ACK, write byte, ACK, then one STOP.
- R4: With bit 0 at 1 (read), the bus carries START, {addr,0}, ACK, byte address, ACK, repeated START, {addr,1}, ACK, eight slave-driven bits, master NACK (line high), STOP. The received byte appears on rdata_o.
- R5: state_o[15:8] is 0x00 while busy. It becomes 0x80 on success, giving state_o=0x8000. It becomes 0x81 on a missing acknowledge, giving state_o=0x8100. state_o[7:0] holds the phase code: 0x03 first address, 0x05 byte address, 0x09 second address or write byte, 0x40 repeated start, 0x80 read byte and NACK, 0x20 stop, 0x00 idle.
- R6: A high data line at the SCL rise of any acknowledge slot ends the access in that cycle. After that there is no further SCL edge and no STOP, and scl_o stays 1.
- R7: Every SCL low interval lasts exactly period_i ticks of tick_i. period_i must be at least 2.
- R8: Data bits go out MSB first, and sda_oe_o changes in a data bit only after SCL has fallen.
- R9: During the read byte, the data line is sampled at each SCL rise and shifted in at the LSB.
- R10: A START or repeated START holds SCL high for one extra interval before the line is pulled low. A STOP holds the line low through the SCL rise and releases it one interval later.
- R11: init_i sets scl_o=1, sda_oe_o=0 and the phase to idle, and stops all bus activity. It takes priority over a start strobe in the same cycle.
- R12: Start strobes that arrive while busy are ignored, and so are request input changes made during the access.
- R13: sda_oe_o is 0 in every acknowledge slot and throughout the read byte.
- R14: irq_o pulses for exactly one cycle per completed or aborted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick enable |
| period_i | input | PERIOD_W | SCL half-period in ticks (at least 2) |
| init_i | input | 1 | Release both lines and abandon any access |
| start_i | input | 1 | Start strobe |
| slave_addr_i | input | 8 | 7-bit slave address in [7:1], read when bit 0 is 1 |
| byte_addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Byte to write |
| sda_i | input | 1 | Sampled data line |
| scl_o | output | 1 | Clock line |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| rdata_o | output | 8 | Byte received by the last read |
| state_o | output | 16 | {status byte, phase code} |
| irq_o | output | 1 | Completion pulse |

## Verification
The init strobe and the start strobe can fall in the same cycle. The bench pulses both together while the block is idle, and again pulses init in the middle of an access. It then judges that the data-line enable stays released, that the state word stays at the idle value and that no SCL edge or interrupt follows. A start strobe can also arrive while an access is running. The bench injects one with changed request inputs during a write and checks that the bytes seen on the bus and the START and STOP counts still match the first request.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [7:0] {
    PH_IDLE    = 8'h00,
    PH_SLA_W   = 8'h03,
    PH_REG     = 8'h05,
    PH_THIRD   = 8'h09,
    PH_RESTART = 8'h40,
    PH_RDATA   = 8'h80,
    PH_STOP    = 8'h20
  } phase_e;

  localparam logic [7:0] ST_BUSY = 8'h00;
  localparam logic [7:0] ST_OK   = 8'h80;
  localparam logic [7:0] ST_NACK = 8'h81;
endpackage

// File: rtl/i2c_bm_timer.sv
module i2c_bm_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                expire_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                last;

  assign last     = (cnt_q == period_i - 1'b1);
  assign expire_o = run_i && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (tick_i)      cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < period_i);
  p_period_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> period_i >= 2);
endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
  import i2c_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] slave_addr_i,
  input  logic [BYTE_W-1:0] byte_addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              sda_i,
  input  logic              ev_i,
  output logic              busy_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [15:0]       state_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);

  phase_e            phase_q;
  logic              busy_q, scl_q, oe_q, data_q, hold_q, rd_q, irq_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q, addr_q, reg_q, wr_q, rdata_q;
  logic [7:0]        status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      busy_q   <= 1'b0;
      scl_q    <= 1'b1;
      oe_q     <= 1'b0;
      data_q   <= 1'b0;
      hold_q   <= 1'b0;
      rd_q     <= 1'b0;
      irq_q    <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
      reg_q    <= '0;
      wr_q     <= '0;
      rdata_q  <= '0;
      status_q <= ST_BUSY;
    end else begin
      irq_q <= 1'b0;
      if (init_i) begin
        scl_q   <= 1'b1;
        oe_q    <= 1'b0;
        busy_q  <= 1'b0;
        hold_q  <= 1'b0;
        data_q  <= 1'b0;
        phase_q <= PH_IDLE;
      end else if (!busy_q) begin
        if (start_i) begin
          busy_q   <= 1'b1;
          status_q <= ST_BUSY;
          oe_q     <= 1'b1;                  // START: pull data low, clock high
          phase_q  <= PH_SLA_W;
          data_q   <= 1'b1;
          cnt_q    <= CW'(BYTE_W);
          addr_q   <= slave_addr_i;
          reg_q    <= byte_addr_i;
          wr_q     <= wdata_i;
          rd_q     <= slave_addr_i[0];
          sh_q     <= {slave_addr_i[BYTE_W-1:1], 1'b0};
        end
      end else if (ev_i) begin
        if (hold_q) begin
          hold_q <= 1'b0;
          if (phase_q == PH_RESTART) begin
            oe_q    <= 1'b1;
            phase_q <= PH_THIRD;
            data_q  <= 1'b1;
            cnt_q   <= CW'(BYTE_W);
            sh_q    <= {addr_q[BYTE_W-1:1], 1'b1};
          end else begin
            oe_q     <= 1'b0;
            busy_q   <= 1'b0;
            phase_q  <= PH_IDLE;
            status_q <= ST_OK;
            irq_q    <= 1'b1;
          end
        end else if (scl_q) begin
          scl_q <= 1'b0;
          if (data_q) begin
            if (phase_q == PH_RDATA) oe_q <= 1'b0;
            else begin
              oe_q <= ~sh_q[BYTE_W-1];
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
            end
          end else begin
            oe_q <= (phase_q == PH_STOP);
          end
        end else begin
          scl_q <= 1'b1;
          if (data_q) begin
            if (phase_q == PH_RDATA) begin
              sh_q <= {sh_q[BYTE_W-2:0], sda_i};
              if (cnt_q == CW'(1)) rdata_q <= {sh_q[BYTE_W-2:0], sda_i};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) data_q <= 1'b0;
          end else begin
            unique case (phase_q)
              PH_SLA_W, PH_REG, PH_THIRD: begin
                if (sda_i) begin
                  status_q <= ST_NACK;
                  irq_q    <= 1'b1;
                  busy_q   <= 1'b0;
                  phase_q  <= PH_IDLE;
                end else if (phase_q == PH_SLA_W) begin
                  phase_q <= PH_REG;
                  data_q  <= 1'b1;
                  cnt_q   <= CW'(BYTE_W);
                  sh_q    <= reg_q;
                end else if (phase_q == PH_REG) begin
                  if (rd_q) phase_q <= PH_RESTART;
                  else begin
                    phase_q <= PH_THIRD;
                    data_q  <= 1'b1;
                    cnt_q   <= CW'(BYTE_W);
                    sh_q    <= wr_q;
                  end
                end else if (rd_q) begin
                  phase_q <= PH_RDATA;
                  data_q  <= 1'b1;
                  cnt_q   <= CW'(BYTE_W);
                end else begin
                  phase_q <= PH_STOP;
                end
              end
              PH_RDATA:            phase_q <= PH_STOP;
              PH_RESTART, PH_STOP: hold_q  <= 1'b1;
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = oe_q;
  assign rdata_o  = rdata_q;
  assign state_o  = {status_q, phase_q};
  assign irq_o    = irq_q;

  p_busy_status_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> status_q == ST_BUSY);
  p_irq_done_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> !busy_q && status_q[7]);
  p_irq_single_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_sda_hold_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && data_q && scl_q && $past(busy_q) && $past(data_q) && $past(scl_q)
    |-> $stable(oe_q));
  p_rdata_release_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && phase_q == PH_RDATA |-> !oe_q);
  p_idle_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> scl_q);
  p_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !init_i && !ev_i |=> $stable(phase_q) && $stable(addr_q));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                init_i,
  input  logic                start_i,
  input  logic [BYTE_W-1:0]   slave_addr_i,
  input  logic [BYTE_W-1:0]   byte_addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic                sda_i,
  output logic                scl_o,
  output logic                sda_oe_o,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic [15:0]         state_o,
  output logic                irq_o
);
  logic busy, ev;

  i2c_bm_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy),
    .tick_i   (tick_i),
    .period_i (period_i),
    .expire_o (ev)
  );

  i2c_bm_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_i       (init_i),
    .start_i      (start_i),
    .slave_addr_i (slave_addr_i),
    .byte_addr_i  (byte_addr_i),
    .wdata_i      (wdata_i),
    .sda_i        (sda_i),
    .ev_i         (ev),
    .busy_o       (busy),
    .scl_o        (scl_o),
    .sda_oe_o     (sda_oe_o),
    .rdata_o      (rdata_o),
    .state_o      (state_o),
    .irq_o        (irq_o)
  );
endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic [15:0] period_i = 16'd2;
  logic init_i = 1'b0, start_i = 1'b0;
  logic [7:0] slave_addr_i = '0, byte_addr_i = '0, wdata_i = '0;
  logic scl_o, sda_oe_o, irq_o, sda_line;
  logic [7:0] rdata_o;
  logic [15:0] state_o;
  logic s_drive = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = !(sda_oe_o || s_drive);

  i2c_byte_master uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .period_i(period_i),
    .init_i(init_i), .start_i(start_i), .slave_addr_i(slave_addr_i),
    .byte_addr_i(byte_addr_i), .wdata_i(wdata_i), .sda_i(sda_line),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .rdata_o(rdata_o),
    .state_o(state_o), .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int tdiv = 1;
  int nstarts, nstops, nbytes, irq_cnt, scl_edges, bad_low, lowcnt, ack_idx, nack_at, bitn;
  logic [7:0] bytes_q [0:7];
  logic [7:0] cur, rbyte;
  bit first, slave_tx, mack;
  bit prev_scl = 1, prev_sda = 1;
  int exp_low;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // timebase
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1 >= tdiv) ? 0 : tc + 1;
      tick_i = (tc == 0);
    end
  end

  // bus monitor and slave model
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_o && prev_scl && prev_sda && !sda_line) begin
        nstarts++; bitn = 0; first = 1; slave_tx = 0; cur = '0;
      end else if (scl_o && prev_scl && !prev_sda && sda_line) nstops++;
      if (scl_o != prev_scl) scl_edges++;
      if (scl_o && !prev_scl) begin
        if (lowcnt != exp_low) bad_low++;
        lowcnt = 0;
        if (bitn < 8) begin
          cur = {cur[6:0], sda_line}; bitn++;
          if (bitn == 8) begin
            if (nbytes < 8) bytes_q[nbytes] = cur;
            nbytes++;
          end
        end else begin
          if (slave_tx) begin mack = sda_line; slave_tx = 0; end
          else if (first && cur[0] && !sda_line) slave_tx = 1;
          first = 0; bitn = 0;
        end
      end
      if (!scl_o) lowcnt++;
      if (!scl_o && prev_scl) begin
        if (bitn == 8) begin
          if (slave_tx) s_drive = 0;
          else begin s_drive = (ack_idx != nack_at); ack_idx++; end
        end else if (slave_tx) s_drive = !rbyte[7-bitn];
        else s_drive = 0;
      end
      if (irq_o) irq_cnt++;
      prev_scl = scl_o; prev_sda = sda_line;
    end
  end

  task automatic clear_mon();
    nstarts = 0; nstops = 0; nbytes = 0; irq_cnt = 0; scl_edges = 0; bad_low = 0;
    lowcnt = 0; ack_idx = 0; bitn = 0; first = 0; slave_tx = 0; mack = 0; s_drive = 0;
    for (int i = 0; i < 8; i++) bytes_q[i] = '0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_txn(input bit rd, input int nk, input int p, input int d,
                         input logic [6:0] a, input logic [7:0] ba, input logic [7:0] wd,
                         input logic [7:0] rb, input bit inject);
    int edges_at_end, n_exp, st_exp;
    period_i = 16'(p); tdiv = d; exp_low = p * d;
    nack_at = nk; rbyte = rb;
    slave_addr_i = {a, rd}; byte_addr_i = ba; wdata_i = wd;
    @(negedge clk);
    clear_mon();
    pulse_start();
    chk(scl_o && sda_oe_o && state_o == 16'h0003, "R2 start state", state_o, 16'h0003);
    if (inject) begin
      repeat (10 * p * d) @(negedge clk);
      slave_addr_i = 8'hF3; byte_addr_i = ~ba; wdata_i = ~wd;
      pulse_start();
      chk(state_o[15:8] == 8'h00, "R12 start while busy", state_o, 16'h0005);
    end
    while (irq_cnt == 0) @(negedge clk);
    edges_at_end = scl_edges;
    repeat (12 * p * d) @(negedge clk);
    st_exp = (nk < 0) ? 16'h8000 : 16'h8100;
    chk(state_o == 16'(st_exp), "R5 final state", state_o, st_exp);
    chk(irq_cnt == 1, "R14 irq pulses", irq_cnt, 1);
    chk(bad_low == 0, "R7 scl low time", bad_low, 0);
    chk(scl_o && !sda_oe_o && scl_edges == edges_at_end, "R6 R11 bus quiet after end",
        scl_edges, edges_at_end);
    n_exp = (nk < 0) ? (rd ? 4 : 3) : nk + 1;
    chk(nbytes == n_exp, "R3 R4 byte count", nbytes, n_exp);
    chk(bytes_q[0] == {a, 1'b0}, "R2 R8 first address rw=0", bytes_q[0], {a, 1'b0});
    if (n_exp > 1) chk(bytes_q[1] == ba, "R8 byte address", bytes_q[1], ba);
    if (n_exp > 2) begin
      if (rd) chk(bytes_q[2] == {a, 1'b1}, "R4 second address", bytes_q[2], {a, 1'b1});
      else    chk(bytes_q[2] == wd, "R3 write byte", bytes_q[2], wd);
    end
    chk(nstops == ((nk < 0) ? 1 : 0), "R6 R10 stop count", nstops, (nk < 0) ? 1 : 0);
    chk(nstarts == ((rd && (nk < 0 || nk >= 2)) ? 2 : 1), "R10 start count", nstarts,
        (rd && (nk < 0 || nk >= 2)) ? 2 : 1);
    if (rd && nk < 0) begin
      chk(rdata_o == rb, "R9 read data", rdata_o, rb);
      chk(bytes_q[3] == rb && mack, "R4 R13 nack after read", mack, 1);
    end
  endtask

  initial begin
    int idx = 0;
    logic [15:0] st_before;
    int e0;
    clear_mon();
    nack_at = -1; exp_low = 2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o && !sda_oe_o && state_o == 16'h0000 && !irq_o, "R1 reset state", state_o, 0);

    for (int p = 2; p <= 4; p++)
      for (int d = 1; d <= 2; d++)
        for (int rd = 0; rd <= 1; rd++)
          for (int nk = -1; nk <= 2; nk++) begin
            run_txn(rd[0], nk, p, d, 7'(7'h50 + idx), 8'(idx * 37 + 5),
                    8'(idx * 91 + 3), 8'(idx * 53 + 11), 1'b0);
            idx++;
          end

    // R12: start strobe and changed inputs while busy
    run_txn(1'b0, -1, 3, 1, 7'h2A, 8'h96, 8'hC3, 8'h00, 1'b1);
    run_txn(1'b1, -1, 2, 1, 7'h51, 8'h10, 8'h00, 8'hA5, 1'b1);

    // R11: init in the middle of a transfer
    period_i = 16'd3; tdiv = 1; exp_low = 3; nack_at = -1;
    slave_addr_i = 8'hA0; byte_addr_i = 8'h33; wdata_i = 8'h44;
    clear_mon();
    pulse_start();
    repeat (25) @(negedge clk);
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    chk(scl_o && !sda_oe_o && state_o[7:0] == 8'h00, "R11 init releases", state_o, 0);
    e0 = scl_edges;
    repeat (100) @(negedge clk);
    chk(scl_edges == e0 && irq_cnt == 0, "R11 no activity after init", scl_edges, e0);

    // R11: init and start in the same cycle
    st_before = state_o;
    init_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0; start_i = 1'b0;
    chk(!sda_oe_o && scl_o && state_o == st_before, "R11 init beats start", state_o, st_before);
    repeat (50) @(negedge clk);
    chk(scl_edges == e0 && irq_cnt == 0, "R11 start discarded", scl_edges, e0);

    // recovery after init
    run_txn(1'b1, -1, 2, 1, 7'h3C, 8'h7E, 8'h00, 8'h81, 1'b0);
    finish_run();
  end
endmodule